// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This unit performs the data-memory side of load and store instructions for a 32-bit big-endian core. It takes one decoded memory instruction at a time, forms the effective address, and drives a byte-addressed memory port with a write strobe, per-lane byte enables and lane-steered write data. Loads raise a request, wait for a read-data-valid response and then return the selected bytes, zero-extended, together with the destination register index.

A single fixed address acts as a character-output register. A store of any size that targets it never reaches memory. Instead, the low byte of the store value appears on a separate character output, with a one-cycle strobe. Sub-word accesses whose address is not naturally aligned are dropped silently, and so are opcodes outside the memory group.

Top module: `bl_lsu`

## Requirements
- R1: The address on `mem_addr` is `ra_val + rb_val` when opcode bit 3 is 0, and `ra_val` plus `imm_val` sign-extended from 16 bits when opcode bit 3 is 1. The request is driven combinationally in the issue cycle.
- R2: Bit i of `mem_be` enables data bits [8i+7:8i], and the byte at offset k within a word sits in lane 3-k (big-endian). Opcode bits [1:0] select the size: 00 byte, 01 halfword, 10 word. A byte at offset k enables lane 3-k only. A halfword at offset 0 enables 4'b1100 and at offset 2 enables 4'b0011. A word enables 4'b1111.
- R3: On a store (opcode bit 2 = 1, `mem_we` = 1), the byte size places `st_val[7:0]` on every lane, the halfword size places `st_val[15:0]` on both halves, and the word size places `st_val` unchanged.
- R4: A load (opcode bit 2 = 0) raises `mem_req` with `mem_we` = 0 in its issue cycle. `busy` is 1 from the next cycle until the response arrives.
- R5: In the cycle `mem_rvalid` is seen while `busy` is 1, `wb_en` is 1, `wb_idx` equals the load's `iss_dst`, and `wb_data` holds the addressed byte or halfword zero-extended (halfword offset 0 takes bits [31:16]), or the whole word. `busy` returns to 0 in the next cycle.
- R6: A store to `TX_ADDR` (default 32'hFFFF_FFC0) raises no `mem_req`. In the next cycle `tx_valid` is 1 for exactly one cycle with `tx_char = st_val[7:0]`.
- R7: A halfword with address bit 0 set, or a word with address bits [1:0] not zero, raises no `mem_req` and leaves `busy` at 0.
- R8: An instruction is a memory instruction only when opcode bits [5:4] = 11 and bits [1:0] are not 11. Any other opcode raises no `mem_req`, no `tx_valid` and no `busy`.
- R9: An issue arriving while `busy` is 1 is ignored (no `mem_req`). A `mem_rvalid` arriving while `busy` is 0 gives no `wb_en`.
- R10: During and just after reset, `busy`, `mem_req`, `wb_en` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction presented this cycle |
| iss_op | input | 6 | Primary opcode |
| iss_dst | input | 5 | Destination register index for loads |
| ra_val | input | 32 | Base register value |
| rb_val | input | 32 | Index register value |
| imm_val | input | 16 | Immediate offset |
| st_val | input | 32 | Store source register value |
| busy | output | 1 | A load is waiting for its response |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Zero-extended load result |
| tx_valid | output | 1 | Character output strobe |
| tx_char | output | 8 | Character output byte |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, a 16-bit immediate and the character register at 32'hFFFF_FFC0. With only three sizes, four offsets, two directions and two address forms, this configuration allows a full sweep of every size and offset combination in both the register and the sign-extended immediate forms, with negative immediates included. Each aligned case has its lane pattern and extracted value computed arithmetically, and each misaligned case is confirmed to be dropped. Reaching the top of the address space through the immediate form also lets the character register be hit by both address forms.

// File: rtl/bl_lsu_pkg.sv
package bl_lsu_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_NONE = 2'b11
   } acc_size_e;
endpackage

// File: rtl/bl_lsu_decode.sv
module bl_lsu_decode
   import bl_lsu_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16
) (
   input  logic [5:0]      op,
   input  logic [XLEN-1:0] ra,
   input  logic [XLEN-1:0] rb,
   input  logic [IMM_W-1:0] imm,
   output logic            is_mem,
   output logic            is_store,
   output acc_size_e       size,
   output logic [XLEN-1:0] addr,
   output logic            aligned
);
   localparam int EXT_W = XLEN - IMM_W;

   logic [XLEN-1:0] offset;

   assign size     = acc_size_e'(op[1:0]);
   assign is_store = op[2];
   assign is_mem   = (op[5:4] == 2'b11) && (size != SZ_NONE);
   assign offset   = op[3] ? {{EXT_W{imm[IMM_W-1]}}, imm} : rb;
   assign addr     = ra + offset;

   always_comb begin
      unique case (size)
         SZ_BYTE: aligned = 1'b1;
         SZ_HALF: aligned = ~addr[0];
         SZ_WORD: aligned = (addr[1:0] == 2'b00);
         default: aligned = 1'b0;
      endcase
   end
endmodule

// File: rtl/bl_lsu_steer.sv
module bl_lsu_steer
   import bl_lsu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  acc_size_e       size,
   input  logic [1:0]      off,
   input  logic [XLEN-1:0] st,
   output logic [XLEN/8-1:0] be,
   output logic [XLEN-1:0] wd
);
   localparam int LANES = XLEN / 8;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [1:0] K = 2'(LANES - 1 - i);
      logic       be_l;
      logic [7:0] wd_l;
      always_comb begin
         unique case (size)
            SZ_BYTE: begin
               be_l = (off == K);
               wd_l = st[7:0];
            end
            SZ_HALF: begin
               be_l = (off[1] == K[1]);
               wd_l = K[0] ? st[7:0] : st[15:8];
            end
            default: begin
               be_l = 1'b1;
               wd_l = st[8*i +: 8];
            end
         endcase
      end
      assign be[i]        = be_l;
      assign wd[8*i +: 8] = wd_l;
   end
endmodule

// File: rtl/bl_lsu_extract.sv
module bl_lsu_extract
   import bl_lsu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  acc_size_e       size,
   input  logic [1:0]      off,
   input  logic [XLEN-1:0] rdata,
   output logic [XLEN-1:0] res
);
   logic [XLEN-1:0] shifted;

   assign shifted = rdata >> {~off, 3'b000};

   always_comb begin
      unique case (size)
         SZ_BYTE: res = {{(XLEN-8){1'b0}}, shifted[7:0]};
         SZ_HALF: res = {{(XLEN-16){1'b0}}, (off[1] ? rdata[15:0] : rdata[31:16])};
         default: res = rdata;
      endcase
   end
endmodule

// File: rtl/bl_lsu.sv
module bl_lsu
   import bl_lsu_pkg::*;
#(
   parameter int          XLEN    = 32,
   parameter int          IMM_W   = 16,
   parameter int          RIDX_W  = 5,
   parameter logic [31:0] TX_ADDR = 32'hFFFF_FFC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [5:0]        iss_op,
   input  logic [RIDX_W-1:0] iss_dst,
   input  logic [XLEN-1:0]   ra_val,
   input  logic [XLEN-1:0]   rb_val,
   input  logic [IMM_W-1:0]  imm_val,
   input  logic [XLEN-1:0]   st_val,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [XLEN-1:0]   mem_addr,
   output logic [XLEN/8-1:0] mem_be,
   output logic [XLEN-1:0]   mem_wdata,
   input  logic [XLEN-1:0]   mem_rdata,
   input  logic              mem_rvalid,
   output logic              wb_en,
   output logic [RIDX_W-1:0] wb_idx,
   output logic [XLEN-1:0]   wb_data,
   output logic              tx_valid,
   output logic [7:0]        tx_char
);
   localparam int LANES = XLEN / 8;

   if (XLEN != 32) begin : g_bad_xlen
      $error("bl_lsu: lane mapping is defined for a 32-bit data path only");
   end
   if (IMM_W < 2 || IMM_W > XLEN) begin : g_bad_imm
      $error("bl_lsu: IMM_W must lie between 2 and XLEN");
   end
   if (LANES * 8 != XLEN) begin : g_bad_lanes
      $error("bl_lsu: XLEN must be a whole number of bytes");
   end

   logic            d_mem, d_store, d_aligned, accept, hit_tx;
   acc_size_e       d_size;
   logic [XLEN-1:0] d_addr;

   acc_size_e       pend_size;
   logic [1:0]      pend_off;
   logic [RIDX_W-1:0] pend_dst;

   bl_lsu_decode #(.XLEN(XLEN), .IMM_W(IMM_W)) u_dec (
      .op       (iss_op),
      .ra       (ra_val),
      .rb       (rb_val),
      .imm      (imm_val),
      .is_mem   (d_mem),
      .is_store (d_store),
      .size     (d_size),
      .addr     (d_addr),
      .aligned  (d_aligned)
   );

   bl_lsu_steer #(.XLEN(XLEN)) u_steer (
      .size (d_size),
      .off  (d_addr[1:0]),
      .st   (st_val),
      .be   (mem_be),
      .wd   (mem_wdata)
   );

   bl_lsu_extract #(.XLEN(XLEN)) u_ext (
      .size  (pend_size),
      .off   (pend_off),
      .rdata (mem_rdata),
      .res   (wb_data)
   );

   assign accept   = rst_n && iss_valid && !busy && d_mem && d_aligned;
   assign hit_tx   = d_store && (d_addr == XLEN'(TX_ADDR));
   assign mem_req  = accept && !hit_tx;
   assign mem_we   = d_store;
   assign mem_addr = d_addr;
   assign wb_en    = busy && mem_rvalid;
   assign wb_idx   = pend_dst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         pend_size <= SZ_WORD;
         pend_off  <= 2'b00;
         pend_dst  <= '0;
      end else if (accept && !d_store) begin
         busy      <= 1'b1;
         pend_size <= d_size;
         pend_off  <= d_addr[1:0];
         pend_dst  <= iss_dst;
      end else if (wb_en) begin
         busy      <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_char  <= 8'h00;
      end else begin
         tx_valid <= accept && hit_tx;
         if (accept && hit_tx) tx_char <= st_val[7:0];
      end
   end
endmodule

// File: rtl/bl_lsu_chk.sv
module bl_lsu_chk #(
   parameter int          XLEN    = 32,
   parameter logic [31:0] TX_ADDR = 32'hFFFF_FFC0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [XLEN-1:0]   mem_addr,
   input logic [XLEN/8-1:0] mem_be,
   input logic              wb_en
);
   // R6
   tx_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr != XLEN'(TX_ADDR)));

   // R4
   load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> busy);

   // R9
   busy_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !mem_req);

   // R5
   wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> !busy);

   // R2
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                   mem_be == 4'b1100 || mem_be == 4'b1111));
endmodule

bind bl_lsu bl_lsu_chk #(.XLEN(XLEN), .TX_ADDR(TX_ADDR)) u_chk (.*);

// File: tb/bl_lsu_bench.sv
module bl_lsu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic [5:0]  iss_op = 6'd0;
   logic [4:0]  iss_dst = 5'd0;
   logic [31:0] ra_val = 32'd0, rb_val = 32'd0, st_val = 32'd0;
   logic [15:0] imm_val = 16'd0;
   logic        busy, mem_req, mem_we, wb_en, tx_valid;
   logic [31:0] mem_addr, mem_wdata, wb_data;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = 32'd0;
   logic        mem_rvalid = 1'b0;
   logic [4:0]  wb_idx;
   logic [7:0]  tx_char;

   int nchk = 0;
   int nerr = 0;

   always #2 clk = ~clk;

   bl_lsu u_bl_lsu (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_dst(iss_dst), .ra_val(ra_val), .rb_val(rb_val), .imm_val(imm_val),
      .st_val(st_val), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .wb_en(wb_en),
      .wb_idx(wb_idx), .wb_data(wb_data), .tx_valid(tx_valid), .tx_char(tx_char)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [5:0] op, input logic [4:0] dst, input logic [31:0] ra,
                        input logic [31:0] rb, input logic [15:0] imm, input logic [31:0] sv);
      @(negedge clk);
      iss_valid = 1'b1; iss_op = op; iss_dst = dst;
      ra_val = ra; rb_val = rb; imm_val = imm; st_val = sv;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      iss_valid = 1'b0; mem_rvalid = 1'b0;
      #1;
   endtask

   initial begin
      #(4 * 100000);
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      mem_rvalid = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      // R10 reset state
      chk("R10 busy", 32'(busy), 0);
      chk("R10 mem_req", 32'(mem_req), 0);
      chk("R10 wb_en", 32'(wb_en), 0);
      chk("R10 tx_valid", 32'(tx_valid), 0);
      @(negedge clk);
      rst_n = 1'b1; mem_rvalid = 1'b0;
      #1;
      chk("R10 busy after release", 32'(busy), 0);

      // R1 R2 R3 R4 R5 R7 full sweep
      for (int sz = 0; sz < 3; sz++) begin
         for (int off = 0; off < 4; off++) begin
            for (int st = 0; st < 2; st++) begin
               for (int im = 0; im < 2; im++) begin
                  logic [5:0]  op;
                  logic [31:0] ra, rb, ea, sv, rd, exp_wd, exp_ld;
                  logic [15:0] imm;
                  logic [3:0]  exp_be;
                  logic        ok;
                  op = {2'b11, 1'(im), 1'(st), 2'(sz)};
                  if (im != 0) begin
                     ra = 32'h2000_0004; rb = 32'hDEAD_BEEF;
                     imm = 16'hFFFC + 16'(off);
                     ea = 32'h2000_0000 + 32'(off);
                  end else begin
                     ra = 32'h1000_0100 + 32'(sz * 16); rb = 32'(off);
                     imm = 16'h7777;
                     ea = ra + 32'(off);
                  end
                  sv = 32'h8C4D_2E1F ^ (32'(off) << 4) ^ (32'(sz) << 12);
                  rd = 32'hA1B2_C3D4 ^ (32'(off) << 20) ^ 32'(sz);
                  ok = (sz == 0) || (sz == 1 && (off % 2) == 0) || (off == 0);
                  case (sz)
                     0: begin
                        exp_be = 4'b1000 >> off; exp_wd = {4{sv[7:0]}};
                        exp_ld = (rd >> (8 * (3 - off))) & 32'hFF;
                     end
                     1: begin
                        exp_be = (off >= 2) ? 4'b0011 : 4'b1100; exp_wd = {2{sv[15:0]}};
                        exp_ld = (off >= 2) ? (rd & 32'hFFFF) : (rd >> 16);
                     end
                     default: begin
                        exp_be = 4'b1111; exp_wd = sv; exp_ld = rd;
                     end
                  endcase
                  issue(op, 5'(7 + off + sz), ra, rb, imm, sv);
                  if (!ok) begin
                     chk("R7 misaligned mem_req", 32'(mem_req), 0);
                     idle();
                     chk("R7 misaligned busy", 32'(busy), 0);
                     chk("R7 misaligned tx_valid", 32'(tx_valid), 0);
                  end else begin
                     chk("R1 mem_addr", mem_addr, ea);
                     chk("R2 mem_be", 32'(mem_be), 32'(exp_be));
                     chk("R4 mem_req", 32'(mem_req), 1);
                     chk("R4 mem_we", 32'(mem_we), 32'(st));
                     if (st != 0) begin
                        chk("R3 mem_wdata", mem_wdata, exp_wd);
                        idle();
                        chk("R3 store leaves busy low", 32'(busy), 0);
                     end else begin
                        @(negedge clk);
                        iss_valid = 1'b0; mem_rvalid = 1'b1; mem_rdata = rd;
                        #1;
                        chk("R4 busy while waiting", 32'(busy), 1);
                        chk("R5 wb_en", 32'(wb_en), 1);
                        chk("R5 wb_idx", 32'(wb_idx), 32'(7 + off + sz));
                        chk("R5 wb_data", wb_data, exp_ld);
                        idle();
                        chk("R5 busy released", 32'(busy), 0);
                        chk("R5 wb_en dropped", 32'(wb_en), 0);
                     end
                  end
               end
            end
         end
      end

      // R6 register form, byte store
      issue(6'b110100, 5'd1, 32'hFFFF_FF00, 32'h0000_00C0, 16'h0, 32'h1234_5641);
      chk("R6 no mem_req (reg form)", 32'(mem_req), 0);
      idle();
      chk("R6 tx_valid", 32'(tx_valid), 1);
      chk("R6 tx_char", 32'(tx_char), 32'h41);
      idle();
      chk("R6 tx_valid one cycle", 32'(tx_valid), 0);

      // R6 immediate form, word store, negative immediate
      issue(6'b111110, 5'd1, 32'h0000_0000, 32'h0, 16'hFFC0, 32'hCAFE_F05A);
      chk("R6 no mem_req (imm form)", 32'(mem_req), 0);
      idle();
      chk("R6 tx_valid imm", 32'(tx_valid), 1);
      chk("R6 tx_char imm", 32'(tx_char), 32'h5A);
      idle();
      chk("R6 tx_valid drop imm", 32'(tx_valid), 0);

      // R8 opcodes outside the memory group
      for (int k = 0; k < 4; k++) begin
         logic [5:0] bad;
         case (k)
            0: bad = 6'b110011;
            1: bad = 6'b110111;
            2: bad = 6'b000000;
            default: bad = 6'b100010;
         endcase
         issue(bad, 5'd3, 32'h4000_0000, 32'h0, 16'h0, 32'h55);
         chk("R8 no mem_req", 32'(mem_req), 0);
         idle();
         chk("R8 busy low", 32'(busy), 0);
         chk("R8 tx_valid low", 32'(tx_valid), 0);
      end

      // R9 issue while busy is ignored
      issue(6'b110010, 5'd9, 32'h3000_0000, 32'h0, 16'h0, 32'h0);
      chk("R9 load request", 32'(mem_req), 1);
      issue(6'b110110, 5'd2, 32'h3000_0010, 32'h0, 16'h0, 32'h7777_7777);
      chk("R9 store while busy dropped", 32'(mem_req), 0);
      @(negedge clk);
      iss_valid = 1'b0; mem_rvalid = 1'b1; mem_rdata = 32'h0BAD_F00D;
      #1;
      chk("R9 pending load completes", wb_data, 32'h0BAD_F00D);
      chk("R9 wb_idx kept", 32'(wb_idx), 9);
      idle();
      chk("R9 no delayed store", 32'(mem_req), 0);

      // R9 response while idle
      @(negedge clk);
      mem_rvalid = 1'b1; mem_rdata = 32'hFFFF_FFFF;
      #1;
      chk("R9 stray rvalid no wb_en", 32'(wb_en), 0);
      idle();
      chk("R9 stray rvalid busy low", 32'(busy), 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule